// File: doc/BRIEF.md
# Bit-Interleaved 3D Address Walker with Segment-Fault Detection

This block holds the current position in a 32x32x32 array as one 15-bit address whose bits interleave the three 5-bit coordinates i, j and k. Nearby array elements therefore get nearby addresses, so a slow backing store can be paged in segments of 128 consecutive addresses. The block supports two kinds of update. A load builds the whole address from three coordinates. A step adds or subtracts one on a single coordinate, and it works directly on the interleaved word.

After every accepted update the block compares the segment index of the new address with the segment that is marked as resident. When they differ it raises a fault. The fault stays up, and new commands are held off, until the page-loaded acknowledge marks the new segment as resident. The block also gathers the interleaved bits back into three coordinate outputs.

Top module: `zorder_walker`

## Requirements
- R1: A load places coordinate bit t of i at address bit 3t, of j at bit 3t+1 and of k at bit 3t+2. The new address is visible one clock after the command.
- R2: When both cmd_load and cmd_step are high on an accepted command, the load is performed and the step is ignored.
- R3: A step with dir=0 adds one to the coordinate chosen by axis (0=i, 1=j, 2=k). It wraps from 31 to 0 and leaves the other two coordinates' address bits unchanged.
- R4: A step with dir=1 subtracts one from the chosen coordinate. It wraps from 0 to 31 and leaves the other coordinates unchanged.
- R5: A step with axis code 3 leaves the address unchanged.
- R6: The segment index is address bits 14..7. After reset no segment is resident, so the first accepted command always raises fault.
- R7: One clock after an accepted command, fault is 1 exactly when the new segment index differs from the resident one.
- R8: While fault is 1, ready is 0 and commands are refused: the address does not change.
- R9: A page_loaded pulse while fault is 1 makes the current segment resident and clears fault on the next clock. A page_loaded pulse while fault is 0 has no effect.
- R10: pos_i, pos_j and pos_k always equal the coordinates held in the current address.
- R11: After reset the address is 0, fault is 0 and ready is 1.
- R12: A cycle with cmd_valid low, or with neither cmd_load nor cmd_step set, leaves the address and the fault unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_load | input | 1 | Load from coordinates |
| cmd_step | input | 1 | Unit step on one axis |
| cmd_axis | input | 2 | Axis select: 0=i, 1=j, 2=k, 3=none |
| cmd_dir | input | 1 | 0 = increment, 1 = decrement |
| coord_i | input | 5 | Load value for i |
| coord_j | input | 5 | Load value for j |
| coord_k | input | 5 | Load value for k |
| page_loaded | input | 1 | Acknowledge that the pending segment is now resident |
| ready | output | 1 | High when a command can be accepted |
| fault | output | 1 | Segment of the current address is not resident |
| addr | output | 15 | Interleaved address |
| pos_i | output | 5 | Coordinate i gathered from addr |
| pos_j | output | 5 | Coordinate j gathered from addr |
| pos_k | output | 5 | Coordinate k gathered from addr |

## Verification
Two things can reach the block in the same cycle: a new command and the page_loaded acknowledge of a pending fault. The bench presents a step and page_loaded on the same clock edge while a fault is pending. It then expects the fault to clear, the address to stay where it was because the command was refused, and the current segment to become resident. A later step inside that segment is expected to leave fault low. A second same-cycle case sets load and step together, and the bench expects the result to match the load alone.

// File: rtl/zw_pkg.sv
package zw_pkg;

    localparam int COORD_W_DEF = 5;
    localparam int AXES        = 3;
    localparam int OFS_W_DEF   = 7;

    typedef enum logic [1:0] {
        AX_I    = 2'd0,
        AX_J    = 2'd1,
        AX_K    = 2'd2,
        AX_NONE = 2'd3
    } axis_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic  load;
        logic  step;
        axis_e axis;
        dir_e  dir;
    } op_t;

endpackage

// File: rtl/zw_spread.sv
module zw_spread #(
    parameter int COORD_W = zw_pkg::COORD_W_DEF,
    localparam int AXES   = zw_pkg::AXES,
    localparam int ADDR_W = COORD_W * AXES
) (
    input  logic [AXES*COORD_W-1:0] coords,
    output logic [ADDR_W-1:0]       addr
);
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        for (genvar t = 0; t < COORD_W; t++) begin : g_bit
            assign addr[t*AXES + a] = coords[a*COORD_W + t];
        end
    end
endmodule

// File: rtl/zw_gather.sv
module zw_gather #(
    parameter int COORD_W = zw_pkg::COORD_W_DEF,
    localparam int AXES   = zw_pkg::AXES,
    localparam int ADDR_W = COORD_W * AXES
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic [AXES*COORD_W-1:0] coords
);
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        for (genvar t = 0; t < COORD_W; t++) begin : g_bit
            assign coords[a*COORD_W + t] = addr[t*AXES + a];
        end
    end
endmodule

// File: rtl/zw_stepper.sv
module zw_stepper #(
    parameter int COORD_W = zw_pkg::COORD_W_DEF,
    localparam int AXES   = zw_pkg::AXES,
    localparam int ADDR_W = COORD_W * AXES
) (
    input  logic [ADDR_W-1:0] cur,
    input  zw_pkg::axis_e     axis,
    input  zw_pkg::dir_e      dir,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] lane
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    function automatic logic [ADDR_W-1:0] lane_of(int a);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int t = 0; t < COORD_W; t++) m[t*AXES + a] = 1'b1;
        return m;
    endfunction

    logic [ADDR_W-1:0] up_val, dn_val;

    always_comb begin
        lane = '0;
        for (int a = 0; a < AXES; a++) begin
            if (int'(axis) == a) lane = lane_of(a);
        end
    end

    // Unused positions are forced to 1 so the carry jumps over them;
    // for the borrow they are forced to 0 so it jumps over them.
    assign up_val = ((cur | ~lane) + ONE) & lane;
    assign dn_val = ((cur & lane) - ONE) & lane;
    assign nxt    = (cur & ~lane) | ((dir == zw_pkg::DIR_UP) ? up_val : dn_val);
endmodule

// File: rtl/zw_seg_track.sv
module zw_seg_track #(
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [SEG_W-1:0] new_seg,
    input  logic [SEG_W-1:0] cur_seg,
    input  logic             ack,
    output logic             fault
);
    logic             res_valid;
    logic [SEG_W-1:0] res_seg;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault     <= 1'b0;
            res_valid <= 1'b0;
            res_seg   <= '0;
        end else if (upd) begin
            fault <= !(res_valid && (new_seg == res_seg));
        end else if (ack && fault) begin
            res_seg   <= cur_seg;
            res_valid <= 1'b1;
            fault     <= 1'b0;
        end
    end

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && fault && !upd) |=> (!fault && res_valid && res_seg == $past(cur_seg)));

    assert_same_seg_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (upd && res_valid && new_seg == res_seg) |=> !fault);

    assert_no_resident_faults_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && !res_valid) |=> fault);
endmodule

// File: rtl/zorder_walker.sv
module zorder_walker #(
    parameter int COORD_W = zw_pkg::COORD_W_DEF,
    parameter int OFS_W   = zw_pkg::OFS_W_DEF,
    localparam int AXES   = zw_pkg::AXES,
    localparam int ADDR_W = COORD_W * AXES,
    localparam int SEG_W  = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_load,
    input  logic               cmd_step,
    input  logic [1:0]         cmd_axis,
    input  logic               cmd_dir,
    input  logic [COORD_W-1:0] coord_i,
    input  logic [COORD_W-1:0] coord_j,
    input  logic [COORD_W-1:0] coord_k,
    input  logic               page_loaded,
    output logic               ready,
    output logic               fault,
    output logic [ADDR_W-1:0]  addr,
    output logic [COORD_W-1:0] pos_i,
    output logic [COORD_W-1:0] pos_j,
    output logic [COORD_W-1:0] pos_k
);
    zw_pkg::op_t             op;
    logic                    acc;
    logic [ADDR_W-1:0]       load_addr, step_addr, step_lane, nxt_addr;
    logic [AXES*COORD_W-1:0] pos_flat;

    assign op.load = cmd_load;
    assign op.step = cmd_step;
    assign op.axis = zw_pkg::axis_e'(cmd_axis);
    assign op.dir  = zw_pkg::dir_e'(cmd_dir);

    assign ready = !fault;
    assign acc   = cmd_valid && ready && (op.load || op.step);

    zw_spread #(.COORD_W(COORD_W)) u_spread (
        .coords ({coord_k, coord_j, coord_i}),
        .addr   (load_addr)
    );

    zw_stepper #(.COORD_W(COORD_W)) u_step (
        .cur  (addr),
        .axis (op.axis),
        .dir  (op.dir),
        .nxt  (step_addr),
        .lane (step_lane)
    );

    assign nxt_addr = op.load ? load_addr : step_addr;

    always_ff @(posedge clk) begin
        if (rst)      addr <= '0;
        else if (acc) addr <= nxt_addr;
    end

    zw_seg_track #(.SEG_W(SEG_W)) u_seg (
        .clk     (clk),
        .rst     (rst),
        .upd     (acc),
        .new_seg (nxt_addr[ADDR_W-1 -: SEG_W]),
        .cur_seg (addr[ADDR_W-1 -: SEG_W]),
        .ack     (page_loaded),
        .fault   (fault)
    );

    zw_gather #(.COORD_W(COORD_W)) u_gather (
        .addr   (addr),
        .coords (pos_flat)
    );

    assign pos_i = pos_flat[0*COORD_W +: COORD_W];
    assign pos_j = pos_flat[1*COORD_W +: COORD_W];
    assign pos_k = pos_flat[2*COORD_W +: COORD_W];

    assert_step_confined_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && !cmd_load) |=> (((addr ^ $past(addr)) & ~$past(step_lane)) == '0));

    assert_refused_hold_R8: assert property (@(posedge clk) disable iff (rst)
        fault |=> $stable(addr));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(addr));

    assert_load_decode_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_load) |=> (pos_i == $past(coord_i) && pos_j == $past(coord_j)
                               && pos_k == $past(coord_k)));
endmodule

// File: tb/sim_zorder_walker.sv
module sim_zorder_walker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_load, cmd_step, cmd_dir, page_loaded;
    logic [1:0] cmd_axis;
    logic [4:0] coord_i, coord_j, coord_k;
    logic       ready, fault;
    logic [14:0] addr;
    logic [4:0] pos_i, pos_j, pos_k;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    int          mc[3];
    logic [14:0] maddr;
    bit          mfault, mrv;
    int          mrs;

    always #(CLK_PERIOD/2) clk = ~clk;

    zorder_walker u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_load(cmd_load),
        .cmd_step(cmd_step), .cmd_axis(cmd_axis), .cmd_dir(cmd_dir),
        .coord_i(coord_i), .coord_j(coord_j), .coord_k(coord_k),
        .page_loaded(page_loaded), .ready(ready), .fault(fault), .addr(addr),
        .pos_i(pos_i), .pos_j(pos_j), .pos_k(pos_k)
    );

    function automatic logic [14:0] ref_addr(int i, int j, int k);
        logic [14:0] r = '0;
        for (int t = 0; t < 5; t++) begin
            r[3*t]     = 1'((i >> t) & 1);
            r[3*t + 1] = 1'((j >> t) & 1);
            r[3*t + 2] = 1'((k >> t) & 1);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " addr"},  32'(addr),  32'(maddr));
        chk({tag, " fault"}, 32'(fault), 32'(mfault));
        chk({tag, " ready"}, 32'(ready), 32'(!mfault));
        chk({tag, " pos R10"}, {17'd0, pos_k, pos_j, pos_i},
            {17'd0, 5'(mc[2]), 5'(mc[1]), 5'(mc[0])});
    endtask

    task automatic send(bit v, bit ld, bit st, int ax, bit dn,
                        int ci, int cj, int ck, bit pl, string tag);
        bit acc, ack;
        @(negedge clk);
        cmd_valid = v; cmd_load = ld; cmd_step = st;
        cmd_axis = 2'(ax); cmd_dir = dn;
        coord_i = 5'(ci); coord_j = 5'(cj); coord_k = 5'(ck);
        page_loaded = pl;
        @(negedge clk);
        cmd_valid = 0; cmd_load = 0; cmd_step = 0; page_loaded = 0;
        acc = v && !mfault && (ld || st);
        ack = pl && mfault;
        if (acc) begin
            if (ld) begin
                mc[0] = ci; mc[1] = cj; mc[2] = ck;
            end else if (ax < 3) begin
                mc[ax] = (mc[ax] + (dn ? 31 : 1)) & 31;
            end
            maddr  = ref_addr(mc[0], mc[1], mc[2]);
            mfault = !(mrv && int'(maddr >> 7) == mrs);
        end else if (ack) begin
            mrs = int'(maddr >> 7); mrv = 1; mfault = 0;
        end
        check_all(tag);
    endtask

    task automatic ack_if_fault(string tag);
        if (mfault) send(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic t_reset;
        rst = 1; cmd_valid = 0; cmd_load = 0; cmd_step = 0; cmd_axis = 0;
        cmd_dir = 0; coord_i = 0; coord_j = 0; coord_k = 0; page_loaded = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        mc[0] = 0; mc[1] = 0; mc[2] = 0; maddr = 0; mfault = 0; mrv = 0; mrs = 0;
        check_all("R11 reset");
    endtask

    task automatic t_load;
        send(1, 1, 0, 0, 0, 5'b10101, 5'b01100, 5'b00011, 0, "R1 load");
        chk("R6 first access faults", 32'(fault), 1);
        ack_if_fault("R9 ack");
        chk("R9 fault cleared", 32'(fault), 0);
        send(1, 1, 0, 0, 0, 5'b10100, 5'b01101, 5'b00010, 0, "R7 same segment");
        chk("R7 no fault same segment", 32'(fault), 0);
        send(1, 1, 0, 0, 0, 31, 0, 31, 0, "R7 other segment");
        chk("R7 fault new segment", 32'(fault), 1);
        chk("R1 placement", 32'(addr), 32'(15'b101101101101101));
    endtask

    task automatic t_refuse;
        send(1, 0, 1, 0, 0, 0, 0, 0, 0, "R8 refused while fault");
        chk("R8 ready low", 32'(ready), 0);
        ack_if_fault("R9 ack");
    endtask

    task automatic t_collide;
        send(1, 1, 0, 0, 0, 0, 0, 0, 0, "R6 load corner");
        chk("R7 fault on move", 32'(fault), 1);
        send(1, 0, 1, 0, 0, 0, 0, 0, 1, "R9 ack with command same cycle");
        chk("R8 command dropped", 32'(addr), 0);
        send(1, 0, 1, 1, 0, 0, 0, 0, 0, "R9 resident after collision");
        chk("R9 no fault in resident segment", 32'(fault), 0);
    endtask

    task automatic t_wrap;
        send(1, 1, 0, 0, 0, 31, 31, 31, 0, "R1 load max");
        ack_if_fault("R9 ack");
        for (int ax = 0; ax < 3; ax++) begin
            send(1, 0, 1, ax, 0, 0, 0, 0, 0, "R3 increment wraps 31 to 0");
            ack_if_fault("R9 ack");
        end
        chk("R3 all wrapped", 32'(addr), 0);
        for (int ax = 0; ax < 3; ax++) begin
            send(1, 0, 1, ax, 1, 0, 0, 0, 0, "R4 decrement wraps 0 to 31");
            ack_if_fault("R9 ack");
        end
        chk("R4 all max", 32'(addr), 32'h7fff);
    endtask

    task automatic t_misc;
        send(1, 0, 1, 3, 0, 0, 0, 0, 0, "R5 axis none up");
        send(1, 0, 1, 3, 1, 0, 0, 0, 0, "R5 axis none down");
        chk("R5 unchanged", 32'(addr), 32'h7fff);
        send(1, 1, 1, 0, 0, 7, 3, 9, 0, "R2 load wins");
        ack_if_fault("R9 ack");
        send(0, 1, 1, 2, 0, 1, 1, 1, 0, "R12 valid low");
        send(1, 0, 0, 2, 0, 1, 1, 1, 0, "R12 no op bits");
        send(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 ack without fault ignored");
        send(1, 0, 1, 0, 0, 0, 0, 0, 0, "R9 resident kept after stray ack");
    endtask

    task automatic t_walk;
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 16);
            if (r == 0)
                send(1, 1, 0, 0, 0, int'($urandom % 32), int'($urandom % 32),
                     int'($urandom % 32), 0, "R1 walk load");
            else
                send(1, 0, 1, r % 3, r[3], 0, 0, 0, 0, "R3 R4 R7 walk step");
            ack_if_fault("R9 walk ack");
        end
    endtask

    initial begin
        t_reset();
        t_load();
        t_refuse();
        t_collide();
        t_wrap();
        t_misc();
        t_walk();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nbad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule